// File: doc/BRIEF.md
# Byte Port for a 16-bit Capture/TOP Register

This block connects a 16-bit register to an 8-bit processor bus so that whole 16-bit values move in one step, never as two halves that can tear. A single byte-wide holding latch is shared by the 16-bit locations on the bus. Reading a low byte copies the matching high byte into that latch on the same edge. A later read of a high location returns the latch, so the two bytes always come from one snapshot. For writes, software puts the upper byte into the latch first. The low-byte write then loads all sixteen bits on one clock edge.

The register has two sources. Hardware loads it from a capture input. Software loads it through the bus, but only while the waveform mode input selects a mode in which the register sets the counter's TOP value. In every other mode the bus cannot change it. A second, read-only 16-bit word (for example, a live count) sits at its own pair of addresses and uses the same latch. This shows that interleaving accesses to another wide register corrupts a transfer in progress. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `reg16_byte_port`

## Requirements
- R1: During reset and after it, `reg_value` reads 0, `bus_rdata` reads 0, and the holding latch holds 0. The latch is observed through a high-byte read.
- R2: A read of `CAP_BASE` returns `reg_value[7:0]` on `bus_rdata` in the cycle after the strobe. The same edge copies `reg_value[15:8]` into the holding latch.
- R3: A read of `CAP_BASE+1` or `AUX_BASE+1` returns the holding latch, not the live high byte, and leaves the latch unchanged.
- R4: A write to `CAP_BASE+1` or `AUX_BASE+1` loads `bus_wdata` into the holding latch in any mode. It does not change `reg_value`.
- R5: A write to `CAP_BASE` that is accepted sets `reg_value` to {latch, `bus_wdata`} on a single edge. The new value is visible in the next cycle.
- R6: A write to `CAP_BASE` is accepted only when bit `wave_mode` of `TOP_MODE_MASK` is set. With the default mask, those modes are 8, 10, 12 and 14. In any other mode the write leaves `reg_value` unchanged.
- R7: A read of `AUX_BASE` returns `aux_word[7:0]` and copies `aux_word[15:8]` into the same holding latch. A write to `AUX_BASE` is ignored.
- R8: `cap_load` loads `cap_value` into `reg_value` on the next edge. If an accepted write to `CAP_BASE` falls in the same cycle, the bus write wins. In modes that do not accept the write, the capture wins.
- R9: When `bus_rd` and `bus_wr` are both high, only the write acts and `bus_rdata` holds its value. A read of any address outside the four mapped locations returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the strobe |
| wave_mode | input | MODE_W | Current waveform mode |
| cap_load | input | 1 | Hardware capture strobe |
| cap_value | input | 16 | Value to capture |
| aux_word | input | 16 | Read-only second wide word sharing the latch |
| reg_value | output | 16 | Current content of the capture/TOP register |

## Verification
Two functions can act on the register in the same cycle: the hardware capture load and the committing low-byte bus write. The bench provokes this collision by raising `cap_load` in the same cycle as the low-byte write, once in a TOP mode and once in a non-TOP mode. It then judges the result by whether `reg_value` holds the bus-composed word or the captured word. A second collision is provoked by asserting a read and a write together. Here the write must take effect and the read data output must stay put.

// File: rtl/reg16_pkg.sv
package reg16_pkg;

  // Decoded, qualified bus operation for one cycle.
  typedef struct packed {
    logic rd_cap_lo;
    logic rd_cap_hi;
    logic rd_aux_lo;
    logic rd_aux_hi;
    logic rd_other;
    logic wr_cap_lo;
    logic wr_hi;
  } bus_op_t;

endpackage

// File: rtl/reg16_rst_sync.sv
module reg16_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/reg16_addr_decode.sv
module reg16_addr_decode
  import reg16_pkg::*;
#(
  parameter int                ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] CAP_BASE = 6'h24,
  parameter logic [ADDR_W-1:0] AUX_BASE = 6'h2C
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output bus_op_t           op
);

  localparam logic [ADDR_W-1:0] CAP_HI = ADDR_W'(CAP_BASE + 1'b1);
  localparam logic [ADDR_W-1:0] AUX_HI = ADDR_W'(AUX_BASE + 1'b1);

  logic hit_cap_lo, hit_cap_hi, hit_aux_lo, hit_aux_hi, rd_only;

  always_comb begin
    hit_cap_lo = (bus_addr == CAP_BASE);
    hit_cap_hi = (bus_addr == CAP_HI);
    hit_aux_lo = (bus_addr == AUX_BASE);
    hit_aux_hi = (bus_addr == AUX_HI);
    // A write in the same cycle suppresses the read.
    rd_only    = bus_rd & ~bus_wr;

    op.rd_cap_lo = rd_only & hit_cap_lo;
    op.rd_cap_hi = rd_only & hit_cap_hi;
    op.rd_aux_lo = rd_only & hit_aux_lo;
    op.rd_aux_hi = rd_only & hit_aux_hi;
    op.rd_other  = rd_only & ~(hit_cap_lo | hit_cap_hi | hit_aux_lo | hit_aux_hi);
    op.wr_cap_lo = bus_wr & hit_cap_lo;
    op.wr_hi     = bus_wr & (hit_cap_hi | hit_aux_hi);
  end

endmodule

// File: rtl/reg16_temp_latch.sv
module reg16_temp_latch
  import reg16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_op_t    op,
  input  logic [7:0] bus_wdata,
  input  logic [7:0] cap_hi_byte,
  input  logic [7:0] aux_hi_byte,
  output logic [7:0] temp_q
);

  logic [7:0] temp_d;
  logic       temp_en;

  always_comb begin
    temp_en = op.wr_hi | op.rd_cap_lo | op.rd_aux_lo;
    temp_d  = temp_q;
    if (op.wr_hi)          temp_d = bus_wdata;
    else if (op.rd_cap_lo) temp_d = cap_hi_byte;
    else if (op.rd_aux_lo) temp_d = aux_hi_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       temp_q <= '0;
    else if (temp_en) temp_q <= temp_d;
  end

  // A high-byte read must not disturb the shared latch (R3).
  assert_hi_read_keeps_temp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op.rd_cap_hi || op.rd_aux_hi) |=> $stable(temp_q));

  // A low read of the auxiliary word snapshots its upper byte (R7).
  assert_aux_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op.rd_aux_lo |=> (temp_q == $past(aux_hi_byte)));

endmodule

// File: rtl/reg16_word_store.sv
module reg16_word_store
  import reg16_pkg::*;
#(
  parameter int                         MODE_W        = 4,
  parameter logic [(1<<MODE_W)-1:0]     TOP_MODE_MASK = 16'h5500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_t           op,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        temp_q,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic              cap_load,
  input  logic [15:0]       cap_value,
  output logic [15:0]       word_q
);

  localparam int NUM_MODES = 1 << MODE_W;

  logic [NUM_MODES-1:0] mode_sel;
  logic                 top_mode;
  logic                 commit;
  logic                 word_en;
  logic [15:0]          word_d;

  // One-hot mode select, ANDed with the mask of TOP-defining modes.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign mode_sel[m] = (wave_mode == MODE_W'(m)) & TOP_MODE_MASK[m];
  end

  always_comb begin
    top_mode = |mode_sel;
    commit   = op.wr_cap_lo & top_mode;
    word_en  = commit | cap_load;
    word_d   = word_q;
    if (commit)        word_d = {temp_q, bus_wdata};
    else if (cap_load) word_d = cap_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  // Writes outside TOP modes leave the word alone (R6).
  assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op.wr_cap_lo && !top_mode && !cap_load) |=> $stable(word_q));

  // Accepted write lands whole, upper half from the latch (R5).
  assert_atomic_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op.wr_cap_lo && top_mode) |=> (word_q == {$past(temp_q), $past(bus_wdata)}));

  // Capture wins whenever no accepted write competes (R8).
  assert_capture_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_load && !(op.wr_cap_lo && top_mode)) |=> (word_q == $past(cap_value)));

endmodule

// File: rtl/reg16_read_port.sv
module reg16_read_port
  import reg16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_op_t    op,
  input  logic [7:0] cap_lo_byte,
  input  logic [7:0] aux_lo_byte,
  input  logic [7:0] temp_q,
  output logic [7:0] rdata_q
);

  logic [7:0] rdata_d;
  logic       rdata_en;

  always_comb begin
    rdata_en = op.rd_cap_lo | op.rd_cap_hi | op.rd_aux_lo | op.rd_aux_hi | op.rd_other;
    rdata_d  = 8'h00;
    if (op.rd_cap_lo)                     rdata_d = cap_lo_byte;
    else if (op.rd_aux_lo)                rdata_d = aux_lo_byte;
    else if (op.rd_cap_hi || op.rd_aux_hi) rdata_d = temp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

endmodule

// File: rtl/reg16_byte_port.sv
module reg16_byte_port
  import reg16_pkg::*;
#(
  parameter int                     ADDR_W        = 6,
  parameter int                     MODE_W        = 4,
  parameter logic [ADDR_W-1:0]      CAP_BASE      = 6'h24,
  parameter logic [ADDR_W-1:0]      AUX_BASE      = 6'h2C,
  parameter logic [(1<<MODE_W)-1:0] TOP_MODE_MASK = 16'h5500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [MODE_W-1:0] wave_mode,
  input  logic              cap_load,
  input  logic [15:0]       cap_value,
  input  logic [15:0]       aux_word,
  output logic [15:0]       reg_value
);

  logic       rst_sync_n;
  bus_op_t    op;
  logic [7:0] temp_q;

  reg16_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  reg16_addr_decode #(
    .ADDR_W   (ADDR_W),
    .CAP_BASE (CAP_BASE),
    .AUX_BASE (AUX_BASE)
  ) u_decode (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .op       (op)
  );

  reg16_temp_latch u_temp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .op          (op),
    .bus_wdata   (bus_wdata),
    .cap_hi_byte (reg_value[15:8]),
    .aux_hi_byte (aux_word[15:8]),
    .temp_q      (temp_q)
  );

  reg16_word_store #(
    .MODE_W        (MODE_W),
    .TOP_MODE_MASK (TOP_MODE_MASK)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op),
    .bus_wdata (bus_wdata),
    .temp_q    (temp_q),
    .wave_mode (wave_mode),
    .cap_load  (cap_load),
    .cap_value (cap_value),
    .word_q    (reg_value)
  );

  reg16_read_port u_read (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .op          (op),
    .cap_lo_byte (reg_value[7:0]),
    .aux_lo_byte (aux_word[7:0]),
    .temp_q      (temp_q),
    .rdata_q     (bus_rdata)
  );

  // Low read returns the pre-edge low byte and snapshots the high byte (R2).
  assert_lo_read_snapshot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op.rd_cap_lo |=> (bus_rdata == $past(reg_value[7:0])) && (temp_q == $past(reg_value[15:8])));

  // High read returns the latch as it stood, not the live byte (R3).
  assert_hi_read_latch_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op.rd_cap_hi || op.rd_aux_hi) |=> (bus_rdata == $past(temp_q)));

  // A read colliding with a write leaves the read data alone (R9).
  assert_rw_collision_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_wr) |=> $stable(bus_rdata));

  // While the synchronised reset is active everything sits at zero (R1).
  always_comb begin
    if (!rst_sync_n && rst_n === 1'b0)
      assert_reset_clear_R1: assert (reg_value == 16'h0 && bus_rdata == 8'h0 && temp_q == 8'h0);
  end

endmodule

// File: tb/reg16_byte_port_bench.sv
module reg16_byte_port_bench;

  localparam logic [5:0] CAP_LO = 6'h24;
  localparam logic [5:0] CAP_HI = 6'h25;
  localparam logic [5:0] AUX_LO = 6'h2C;
  localparam logic [5:0] AUX_HI = 6'h2D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [3:0]  wave_mode = 4'd0;
  logic        cap_load = 1'b0;
  logic [15:0] cap_value = '0;
  logic [15:0] aux_word = 16'hBEEF;
  logic [15:0] reg_value;

  int n_run = 0;
  int n_fail = 0;

  // Bench-side model, built from the requirements.
  logic [15:0] m_reg = '0;
  logic [7:0]  m_temp = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  reg16_byte_port u_reg16_byte_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wave_mode (wave_mode),
    .cap_load  (cap_load),
    .cap_value (cap_value),
    .aux_word  (aux_word),
    .reg_value (reg_value)
  );

  function automatic logic is_top(input logic [3:0] m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  task automatic chk16(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected byte for each completed read.
  always @(posedge clk) pend <= bus_rd && !bus_wr;

  always @(negedge clk) begin
    if (pend) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read data %h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  // Driver: one bus/capture cycle, updates the model, queues read data.
  task automatic op(input logic rd, input logic wr, input logic [5:0] a,
                    input logic [7:0] d, input logic cl, input logic [15:0] cv,
                    input string tag);
    logic commit;
    logic [7:0] new_temp;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    cap_load = cl; cap_value = cv;
    new_temp = m_temp;
    commit = 1'b0;
    if (rd && !wr) begin
      if (a == CAP_LO)                     begin exp_q.push_back(m_reg[7:0]);    new_temp = m_reg[15:8]; end
      else if (a == AUX_LO)                begin exp_q.push_back(aux_word[7:0]); new_temp = aux_word[15:8]; end
      else if (a == CAP_HI || a == AUX_HI) exp_q.push_back(m_temp);
      else                                 exp_q.push_back(8'h00);
      tag_q.push_back(tag);
    end
    if (wr) begin
      if (a == CAP_HI || a == AUX_HI) new_temp = d;
      if (a == CAP_LO && is_top(wave_mode)) begin
        commit = 1'b1;
        m_reg  = {m_temp, d};
      end
    end
    if (cl && !commit) m_reg = cv;
    m_temp = new_temp;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; cap_load = 1'b0;
    chk16(reg_value, m_reg, tag);
  endtask

  task automatic rd8(input logic [5:0] a, input string tag);
    op(1'b1, 1'b0, a, 8'h00, 1'b0, 16'h0, tag);
  endtask

  task automatic wr8(input logic [5:0] a, input logic [7:0] d, input string tag);
    op(1'b0, 1'b1, a, d, 1'b0, 16'h0, tag);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk16(reg_value, 16'h0, "R1 reg during reset");
    chk16({8'h0, bus_rdata}, 16'h0, "R1 rdata during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk16(reg_value, 16'h0, "R1 reg after reset");
    rd8(CAP_HI, "R1 latch zero after reset");

    // Atomic write in a TOP mode
    wave_mode = 4'd8;
    wr8(CAP_HI, 8'h12, "R4 high write leaves register");
    wr8(CAP_LO, 8'h34, "R5 low write commits word");
    rd8(CAP_LO, "R2 low read");
    rd8(CAP_HI, "R3 high read after low read");

    // Capture, and stale-latch reads
    op(1'b0, 1'b0, 6'h00, 8'h00, 1'b1, 16'hABCD, "R8 capture load");
    rd8(CAP_HI, "R3 high read returns latch not live byte");
    rd8(CAP_LO, "R2 low read after capture");
    rd8(CAP_HI, "R3 high read matches snapshot");
    rd8(CAP_LO, "R2 snapshot before new capture");
    op(1'b0, 1'b0, 6'h00, 8'h00, 1'b1, 16'h5566, "R8 second capture");
    rd8(CAP_HI, "R3 latch keeps older snapshot");

    // Mode gating across all modes
    for (int m = 0; m < 16; m++) begin
      wave_mode = 4'(m);
      wr8(CAP_HI, 8'(8'h40 + m), "R4 high write per mode");
      wr8(CAP_LO, 8'(8'h80 + m), is_top(4'(m)) ? "R6 write accepted in TOP mode"
                                               : "R6 write ignored outside TOP mode");
    end
    wave_mode = 4'd4;
    wr8(CAP_HI, 8'h77, "R4 high write in non-TOP mode");
    wr8(CAP_LO, 8'h88, "R6 non-TOP low write ignored");
    rd8(CAP_HI, "R4 latch loaded in non-TOP mode");

    // Shared latch with the auxiliary word
    wave_mode = 4'd12;
    aux_word = 16'hBEEF;
    wr8(CAP_HI, 8'h11, "R4 high write before interleave");
    rd8(AUX_LO, "R7 aux low read");
    wr8(CAP_LO, 8'h22, "R7 interleaved aux read corrupts transfer");
    rd8(AUX_HI, "R7 aux high read returns shared latch");
    wr8(AUX_LO, 8'h99, "R7 aux low write ignored");
    aux_word = 16'h0F1E;
    rd8(AUX_LO, "R7 aux low read second value");
    wr8(AUX_HI, 8'h6B, "R4 aux high write loads latch");
    wr8(CAP_LO, 8'h7C, "R5 commit uses latch from aux high write");

    // Capture and bus write in the same cycle
    wave_mode = 4'd8;
    wr8(CAP_HI, 8'h3C, "R8 setup");
    op(1'b0, 1'b1, CAP_LO, 8'h5A, 1'b1, 16'h9999, "R8 bus wins in TOP mode");
    wave_mode = 4'd4;
    op(1'b0, 1'b1, CAP_LO, 8'h5A, 1'b1, 16'h4242, "R8 capture wins outside TOP mode");

    // Read and write together, unmapped read
    wave_mode = 4'd14;
    rd8(CAP_LO, "R2 read before collision");
    @(negedge clk);
    held = bus_rdata;
    wr8(CAP_HI, 8'hC3, "R9 setup");
    op(1'b1, 1'b1, CAP_LO, 8'h3C, 1'b0, 16'h0, "R9 write acts on read+write");
    chk16({8'h0, bus_rdata}, {8'h0, held}, "R9 rdata holds on read+write");
    rd8(6'h3F, "R9 unmapped read returns zero");
    rd8(CAP_HI, "R9 latch after collision write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: %0d reads missing expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule